// File: doc/BRIEF.md
# Protection Region Register Bank

This block holds the configuration words of a memory protection unit. Regions are kept in two banks: one for the lower privilege level and one for the hypervisor level. Each region has a 32-bit base word and a 32-bit limit word. Software reaches the bank through a coprocessor-style register port. Each access presents a write strobe, three selector fields (`acc_opc1`, `acc_crm`, `acc_opc2`) and write data. Read data comes back combinationally in the same cycle.

Each bank can be reached in two ways. The first is indirect: a per-bank selector register names one region, and a base/limit register pair acts on that region. The second is direct: alias encodings name a region inside the selector fields. The hypervisor bank has a third path. A packed enable register shows bit 0 of every hypervisor limit word as one bit per region.

Every write that can change a mapping raises a registered one-cycle invalidate pulse. Translation caches downstream use this pulse to flush. Region counts are elaboration parameters.

Top module: `rpb_top`

## Requirements
- R1: A selector write (`acc_crm`=2, `acc_opc2`=1, `acc_opc1`=0 for the lower bank or 4 for the hypervisor bank) takes effect only when the written value is below that bank's region count. A rejected write leaves the selector unchanged. A read of the selector returns its value.
- R2: The selected-word registers (`acc_crm`=3, `acc_opc1`=0 or 4) read and write the base word (`acc_opc2`=0) or the limit word (`acc_opc2`=1) of the region named by the bank's selector.
- R3: An alias access has `acc_crm[3]`=1, `acc_opc1[1]`=0 and `acc_opc2[1]`=0. Its region index is {`acc_opc1[0]`, `acc_crm[2:0]`, `acc_opc2[2]`}, MSB first. `acc_opc1[2]`=1 picks the hypervisor bank. `acc_opc2[0]` picks the limit word (1) or the base word (0). Alias and selected accesses share one storage, and the two banks are separate.
- R4: An alias access whose index is at or above the bank's region count reads zero and does not change any stored word.
- R5: Reading the enable register (`acc_opc1`=4, `acc_crm`=1, `acc_opc2`=1) returns a bitmap. Bit n holds bit 0 of hypervisor limit word n for n < min(count, 32). All higher bits are zero.
- R6: Writing the enable register first drops the bits of unimplemented regions. It then copies bit n into bit 0 of hypervisor limit word n and leaves bits 31:1 of each limit word unchanged.
- R7: `inval_pulse` is high for exactly the cycle after a write to a selected word, an alias word (in range or not) or the enable register. It is low after any other cycle.
- R8: The identity registers (`acc_crm`=0, `acc_opc2`=4) return the hypervisor region count for `acc_opc1`=4 and the lower region count shifted left by 8 for `acc_opc1`=0. Writes to them change nothing.
- R9: Reset clears every base and limit word of both banks and both selectors.
- R10: Any encoding not listed above reads zero. A write to such an encoding changes no state and raises no pulse.
- R11: When `MPU_PRESENT` is 0 or `LO_REGIONS` is 0, both effective region counts are zero. Region counts above 255 are capped at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe for the current access |
| acc_opc1 | input | 3 | First opcode selector field |
| acc_crm | input | 4 | Secondary register selector field |
| acc_opc2 | input | 3 | Second opcode selector field |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Combinational read data for the current access |
| inval_pulse | output | 1 | One-cycle mapping-invalidate pulse |

## Verification
The hardest state to reach from the ports is a region whose limit word has been written along all three paths in turn. The stimulus first writes the limit through the selector path. It then writes another region's limit through its alias encoding. Next it sets and clears the enable register. Finally it reads the same words back through the alias path, which shows that only bit 0 moved and the upper bits survived. Selector values are chosen so that a truncated compare would accept them (for example 0x103 when the hypervisor count is 20), and alias indices above 15 are used to exercise the opcode-derived index bit.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

  localparam int WORD_W      = 32;
  localparam int SEL_W       = 8;
  localparam int AIDX_W      = 5;
  localparam int MAX_REGIONS = 255;
  localparam int MAP_W       = 32;
  localparam int ID_LO_SHIFT = 8;

  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_ID    = 3'd1,
    ACC_SEL   = 3'd2,
    ACC_WORD  = 3'd3,
    ACC_ALIAS = 3'd4,
    ACC_ENMAP = 3'd5
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e           kind;
    logic                hyp;
    logic                is_lim;
    logic [AIDX_W-1:0]   aidx;
  } acc_dec_t;

  // Effective region count of a bank after the presence rules and the cap.
  function automatic int eff_regions(input int present, input int lo_cnt,
                                     input int own_cnt, input int cap);
    if (present == 0 || lo_cnt == 0) return 0;
    if (own_cnt > cap) return cap;
    return own_cnt;
  endfunction

  // Number of regions visible in the packed enable bitmap.
  function automatic int map_span(input int count);
    return (count < MAP_W) ? count : MAP_W;
  endfunction

  // Bitmap mask that keeps only implemented regions.
  function automatic logic [MAP_W-1:0] map_mask(input int count);
    int span;
    span = map_span(count);
    if (span >= MAP_W) return '1;
    return (MAP_W'(1) << span) - MAP_W'(1);
  endfunction

  // Direct alias region index assembled from the selector fields.
  function automatic logic [AIDX_W-1:0] alias_index(input logic [2:0] o1,
                                                    input logic [3:0] crm,
                                                    input logic [2:0] o2);
    return {o1[0], crm[2:0], o2[2]};
  endfunction

  // Selector write acceptance test.
  function automatic logic sel_ok(input logic [WORD_W-1:0] v, input int count);
    return v < WORD_W'(count);
  endfunction

endpackage

// File: rtl/rpb_decode.sv
module rpb_decode
  import rpb_pkg::*;
(
  input  logic [2:0] opc1,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output acc_dec_t   dec
);

  logic hyp_bank;
  logic plain_o1;

  assign hyp_bank = opc1[2];
  assign plain_o1 = (opc1[1:0] == 2'b00);

  always_comb begin
    dec        = '0;
    dec.kind   = ACC_NONE;
    dec.hyp    = hyp_bank;
    dec.is_lim = opc2[0];
    dec.aidx   = alias_index(opc1, crm, opc2);
    if (crm[3]) begin
      if (!opc1[1] && !opc2[1]) dec.kind = ACC_ALIAS;
    end else begin
      case (crm[2:0])
        3'd0: if (plain_o1 && opc2 == 3'd4) dec.kind = ACC_ID;
        3'd1: if (opc1 == 3'd4 && opc2 == 3'd1) dec.kind = ACC_ENMAP;
        3'd2: if (plain_o1 && opc2 == 3'd1) dec.kind = ACC_SEL;
        3'd3: if (plain_o1 && opc2[2:1] == 2'b00) dec.kind = ACC_WORD;
        default: dec.kind = ACC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rpb_bank.sv
module rpb_bank
  import rpb_pkg::*;
#(
  parameter int COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              wr_word,
  input  logic              wr_map,
  input  logic              use_alias,
  input  logic              is_lim,
  input  logic [AIDX_W-1:0] alias_idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [WORD_W-1:0] rd_word,
  output logic [MAP_W-1:0]  en_map
);

  localparam int STORE = (COUNT > 0) ? COUNT : 1;
  localparam int MAP_N = map_span(COUNT);

  logic [SEL_W-1:0]  sel_r;
  logic [SEL_W-1:0]  tgt;
  logic              idx_hit;
  logic [WORD_W-1:0] base_all [STORE];
  logic [WORD_W-1:0] lim_all  [STORE];

  assign tgt     = use_alias ? {{(SEL_W-AIDX_W){1'b0}}, alias_idx} : sel_r;
  assign idx_hit = int'(tgt) < COUNT;
  assign sel_q   = sel_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r <= '0;
    end else if (wr_sel && sel_ok(wdata, COUNT)) begin
      sel_r <= wdata[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < STORE; i++) begin : g_region
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] lim_q;
    logic              hit;

    assign hit = idx_hit && (tgt == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
      end else if (wr_word && hit && !is_lim) begin
        base_q <= wdata;
      end
    end

    if (i < MAP_N) begin : g_mapped
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lim_q <= '0;
        end else if (wr_word && hit && is_lim) begin
          lim_q <= wdata;
        end else if (wr_map) begin
          lim_q[0] <= wdata[i];
        end
      end
    end else begin : g_unmapped
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lim_q <= '0;
        end else if (wr_word && hit && is_lim) begin
          lim_q <= wdata;
        end
      end
    end

    assign base_all[i] = base_q;
    assign lim_all[i]  = lim_q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < STORE; i++) begin
      if (idx_hit && tgt == SEL_W'(i)) begin
        rd_word = is_lim ? lim_all[i] : base_all[i];
      end
    end
  end

  for (genvar n = 0; n < MAP_W; n++) begin : g_map
    if (n < MAP_N) begin : g_live
      assign en_map[n] = lim_all[n][0];
    end else begin : g_dead
      assign en_map[n] = 1'b0;
    end
  end

endmodule

// File: rtl/rpb_top.sv
module rpb_top
  import rpb_pkg::*;
#(
  parameter bit MPU_PRESENT = 1'b1,
  parameter int LO_REGIONS  = 12,
  parameter int HI_REGIONS  = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic [2:0]  acc_opc1,
  input  logic [3:0]  acc_crm,
  input  logic [2:0]  acc_opc2,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        inval_pulse
);

  localparam int LO_EFF = eff_regions(int'(MPU_PRESENT), LO_REGIONS, LO_REGIONS, MAX_REGIONS);
  localparam int HI_EFF = eff_regions(int'(MPU_PRESENT), LO_REGIONS, HI_REGIONS, MAX_REGIONS);

  acc_dec_t          dec;
  logic [SEL_W-1:0]  sel_q_b   [2];
  logic [WORD_W-1:0] rd_word_b [2];
  logic [MAP_W-1:0]  en_map_b  [2];

  // Named internal events for the checker.
  logic              inval_req;
  logic [SEL_W-1:0]  sel_q_hi;
  logic [SEL_W-1:0]  sel_q_lo;
  logic [MAP_W-1:0]  en_map_hi;
  logic              inval_q;

  rpb_decode u_dec (
    .opc1 (acc_opc1),
    .crm  (acc_crm),
    .opc2 (acc_opc2),
    .dec  (dec)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic mine;
    assign mine = (dec.hyp == 1'(b));

    rpb_bank #(
      .COUNT ((b == 1) ? HI_EFF : LO_EFF)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (acc_wr && mine && dec.kind == ACC_SEL),
      .wr_word   (acc_wr && mine && (dec.kind == ACC_WORD || dec.kind == ACC_ALIAS)),
      .wr_map    (acc_wr && mine && dec.kind == ACC_ENMAP),
      .use_alias (dec.kind == ACC_ALIAS),
      .is_lim    (dec.is_lim),
      .alias_idx (dec.aidx),
      .wdata     (acc_wdata),
      .sel_q     (sel_q_b[b]),
      .rd_word   (rd_word_b[b]),
      .en_map    (en_map_b[b])
    );
  end

  assign sel_q_hi  = sel_q_b[1];
  assign sel_q_lo  = sel_q_b[0];
  assign en_map_hi = en_map_b[1];

  assign inval_req = acc_wr && (dec.kind == ACC_WORD || dec.kind == ACC_ALIAS ||
                                dec.kind == ACC_ENMAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inval_q <= 1'b0;
    else        inval_q <= inval_req;
  end

  assign inval_pulse = inval_q;

  always_comb begin
    acc_rdata = '0;
    case (dec.kind)
      ACC_ID:    acc_rdata = dec.hyp ? WORD_W'(HI_EFF) : (WORD_W'(LO_EFF) << ID_LO_SHIFT);
      ACC_SEL:   acc_rdata = WORD_W'(dec.hyp ? sel_q_hi : sel_q_lo);
      ACC_WORD,
      ACC_ALIAS: acc_rdata = rd_word_b[dec.hyp];
      ACC_ENMAP: acc_rdata = en_map_b[dec.hyp];
      default:   acc_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rpb_checks.sv
module rpb_checks
  import rpb_pkg::*;
#(
  parameter bit MPU_PRESENT = 1'b1,
  parameter int LO_REGIONS  = 12,
  parameter int HI_REGIONS  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_wr,
  input logic [2:0]        acc_opc1,
  input logic [3:0]        acc_crm,
  input logic [2:0]        acc_opc2,
  input logic [31:0]       acc_wdata,
  input logic [31:0]       acc_rdata,
  input logic              inval_pulse,
  input logic [SEL_W-1:0]  sel_q_hi,
  input logic [MAP_W-1:0]  en_map_hi
);

  localparam int HI_CNT = eff_regions(int'(MPU_PRESENT), LO_REGIONS, HI_REGIONS, MAX_REGIONS);
  localparam logic [MAP_W-1:0] HI_MASK = map_mask(HI_CNT);

  logic       hit_sel_hi, hit_alias_any, hit_alias_hi, hit_word, hit_map, hit_id_hi;
  logic [4:0] a_idx;

  assign hit_sel_hi    = acc_opc1 == 3'd4 && acc_crm == 4'd2 && acc_opc2 == 3'd1;
  assign hit_alias_any = acc_crm[3] && !acc_opc1[1] && !acc_opc2[1];
  assign hit_alias_hi  = hit_alias_any && acc_opc1[2];
  assign hit_word      = acc_crm == 4'd3 && acc_opc1[1:0] == 2'b00 && acc_opc2[2:1] == 2'b00;
  assign hit_map       = acc_opc1 == 3'd4 && acc_crm == 4'd1 && acc_opc2 == 3'd1;
  assign hit_id_hi     = acc_opc1 == 3'd4 && acc_crm == 4'd0 && acc_opc2 == 3'd4;
  assign a_idx         = {acc_opc1[0], acc_crm[2:0], acc_opc2[2]};

  // R1: an out-of-range selector write leaves the selector alone
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && hit_sel_hi && acc_wdata >= 32'(HI_CNT)) |=> $stable(sel_q_hi));

  // R1: the selector never names an unimplemented region
  p_sel_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_q_hi) < 32'(HI_CNT)) || (sel_q_hi == '0));

  // R4: alias reads past the count return zero
  p_alias_oob_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_alias_hi && {27'b0, a_idx} >= 32'(HI_CNT)) |-> acc_rdata == 32'h0);

  // R6: the bitmap follows the masked write
  p_map_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && hit_map) |=> en_map_hi == ($past(acc_wdata) & HI_MASK));

  // R7: descriptor writes raise the pulse
  p_inval_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && (hit_word || hit_alias_any || hit_map)) |=> inval_pulse);

  // R7: no write, no pulse
  p_inval_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> !inval_pulse);

  // R8: hypervisor identity returns the count
  p_id_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_id_hi |-> acc_rdata == 32'(HI_CNT));

endmodule

bind rpb_top rpb_checks #(
  .MPU_PRESENT (MPU_PRESENT),
  .LO_REGIONS  (LO_REGIONS),
  .HI_REGIONS  (HI_REGIONS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_wr      (acc_wr),
  .acc_opc1    (acc_opc1),
  .acc_crm     (acc_crm),
  .acc_opc2    (acc_opc2),
  .acc_wdata   (acc_wdata),
  .acc_rdata   (acc_rdata),
  .inval_pulse (inval_pulse),
  .sel_q_hi    (sel_q_hi),
  .en_map_hi   (en_map_hi)
);

// File: tb/rpb_top_test.sv
module rpb_top_test;

  localparam int CLK_P = 10;
  localparam int LO_N  = 12;
  localparam int HI_N  = 20;
  localparam int WD    = 20000;

  typedef struct packed {
    logic        wr;
    logic [2:0]  o1;
    logic [3:0]  crm;
    logic [2:0]  o2;
    logic [31:0] wd;
    logic [31:0] ex;
    logic        inv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VT [NV] = '{
    {1'b0,3'd0,4'd0,3'd4,32'h0,32'h00000C00,1'b0,4'd8},       // R8 lower identity
    {1'b0,3'd4,4'd0,3'd4,32'h0,32'h00000014,1'b0,4'd8},       // R8 hyp identity
    {1'b1,3'd4,4'd0,3'd4,32'hFF,32'h0,1'b0,4'd8},             // R8 write ignored
    {1'b0,3'd4,4'd0,3'd4,32'h0,32'h00000014,1'b0,4'd8},       // R8
    {1'b0,3'd4,4'd2,3'd1,32'h0,32'h0,1'b0,4'd9},              // R9 selector reset
    {1'b0,3'd4,4'd3,3'd0,32'h0,32'h0,1'b0,4'd9},              // R9 word reset
    {1'b1,3'd4,4'd2,3'd1,32'd19,32'h0,1'b0,4'd1},             // R1 accept 19
    {1'b0,3'd4,4'd2,3'd1,32'h0,32'd19,1'b0,4'd1},             // R1
    {1'b1,3'd4,4'd2,3'd1,32'd20,32'h0,1'b0,4'd1},             // R1 reject count
    {1'b1,3'd4,4'd2,3'd1,32'h103,32'h0,1'b0,4'd1},            // R1 reject wide value
    {1'b0,3'd4,4'd2,3'd1,32'h0,32'd19,1'b0,4'd1},             // R1 still 19
    {1'b1,3'd4,4'd3,3'd0,32'hAAAA0000,32'h0,1'b1,4'd2},       // R2 selected base
    {1'b1,3'd4,4'd3,3'd1,32'h55550001,32'h0,1'b1,4'd2},       // R2 selected limit
    {1'b0,3'd4,4'd3,3'd0,32'h0,32'hAAAA0000,1'b0,4'd2},       // R2
    {1'b0,3'd4,4'd3,3'd1,32'h0,32'h55550001,1'b0,4'd2},       // R2
    {1'b0,3'd5,4'd9,3'd4,32'h0,32'hAAAA0000,1'b0,4'd3},       // R3 alias 19 base
    {1'b0,3'd5,4'd9,3'd5,32'h0,32'h55550001,1'b0,4'd3},       // R3 alias 19 limit
    {1'b0,3'd4,4'd1,3'd1,32'h0,32'h00080000,1'b0,4'd5},       // R5 bitmap
    {1'b1,3'd4,4'd10,3'd5,32'h12345670,32'h0,1'b1,4'd3},      // R3 alias 5 limit write
    {1'b0,3'd4,4'd1,3'd1,32'h0,32'h00080000,1'b0,4'd5},       // R5
    {1'b1,3'd4,4'd1,3'd1,32'hFFFFFFFF,32'h0,1'b1,4'd6},       // R6 set all
    {1'b0,3'd4,4'd1,3'd1,32'h0,32'h000FFFFF,1'b0,4'd6},       // R6 masked
    {1'b0,3'd4,4'd10,3'd5,32'h0,32'h12345671,1'b0,4'd6},      // R6 upper bits kept
    {1'b0,3'd5,4'd9,3'd5,32'h0,32'h55550001,1'b0,4'd6},       // R6
    {1'b1,3'd4,4'd1,3'd1,32'h0,32'h0,1'b1,4'd6},              // R6 clear all
    {1'b0,3'd4,4'd10,3'd5,32'h0,32'h12345670,1'b0,4'd6},      // R6
    {1'b0,3'd5,4'd9,3'd5,32'h0,32'h55550000,1'b0,4'd6},       // R6
    {1'b0,3'd4,4'd1,3'd1,32'h0,32'h0,1'b0,4'd5},              // R5 empty map
    {1'b1,3'd5,4'd12,3'd4,32'h0000DEAD,32'h0,1'b1,4'd4},      // R4 alias 25 write
    {1'b0,3'd5,4'd12,3'd4,32'h0,32'h0,1'b0,4'd4},             // R4 reads zero
    {1'b0,3'd5,4'd10,3'd0,32'h0,32'h0,1'b0,4'd4},             // R4 alias 20
    {1'b1,3'd0,4'd2,3'd1,32'd11,32'h0,1'b0,4'd1},             // R1 lower accept
    {1'b1,3'd0,4'd2,3'd1,32'd12,32'h0,1'b0,4'd1},             // R1 lower reject
    {1'b0,3'd0,4'd2,3'd1,32'h0,32'd11,1'b0,4'd1},             // R1
    {1'b1,3'd0,4'd3,3'd0,32'hCAFE0000,32'h0,1'b1,4'd2},       // R2 lower base
    {1'b0,3'd0,4'd13,3'd4,32'h0,32'hCAFE0000,1'b0,4'd3},      // R3 lower alias 11
    {1'b0,3'd4,4'd13,3'd4,32'h0,32'h0,1'b0,4'd3},             // R3 banks separate
    {1'b0,3'd0,4'd14,3'd0,32'h0,32'h0,1'b0,4'd4},             // R4 lower alias 12
    {1'b0,3'd1,4'd8,3'd0,32'h0,32'h0,1'b0,4'd4},              // R4 lower alias 16
    {1'b1,3'd0,4'd14,3'd0,32'h0000FFFF,32'h0,1'b1,4'd4},      // R4 oob write
    {1'b0,3'd0,4'd1,3'd1,32'h0,32'h0,1'b0,4'd10},             // R10 map in lower bank
    {1'b1,3'd0,4'd4,3'd0,32'h1,32'h0,1'b0,4'd10},             // R10 unmapped write
    {1'b0,3'd0,4'd4,3'd0,32'h0,32'h0,1'b0,4'd10},             // R10
    {1'b0,3'd2,4'd9,3'd0,32'h0,32'h0,1'b0,4'd10},             // R10
    {1'b0,3'd0,4'd3,3'd0,32'h0,32'hCAFE0000,1'b0,4'd10}       // R10 state intact
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic [2:0]  acc_opc1 = '0;
  logic [3:0]  acc_crm = '0;
  logic [2:0]  acc_opc2 = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_main, rd_off, rd_nolo;
  logic        inv_main, inv_off, inv_nolo;
  logic [31:0] s_rd, s_off, s_nolo;
  logic        s_inv;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rpb_top #(.LO_REGIONS(LO_N), .HI_REGIONS(HI_N)) uut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_opc1(acc_opc1),
    .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .acc_rdata(rd_main), .inval_pulse(inv_main));

  rpb_top #(.MPU_PRESENT(1'b0), .LO_REGIONS(LO_N), .HI_REGIONS(HI_N)) uut_off (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_opc1(acc_opc1),
    .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .acc_rdata(rd_off), .inval_pulse(inv_off));

  rpb_top #(.LO_REGIONS(0), .HI_REGIONS(HI_N)) uut_nolo (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_opc1(acc_opc1),
    .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .acc_rdata(rd_nolo), .inval_pulse(inv_nolo));

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access per cycle: drive at the falling edge, read before the rising
  // edge, sample the registered pulse just after it.
  task automatic run_acc(input logic wr, input logic [2:0] o1, input logic [3:0] crm,
                         input logic [2:0] o2, input logic [31:0] wd);
    @(negedge clk);
    acc_wr = wr; acc_opc1 = o1; acc_crm = crm; acc_opc2 = o2; acc_wdata = wd;
    #(CLK_P/4);
    s_rd = rd_main; s_off = rd_off; s_nolo = rd_nolo;
    @(posedge clk);
    #1;
    s_inv = inv_main;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check(9, "R9 pulse after reset", {31'b0, inv_main}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      run_acc(VT[k].wr, VT[k].o1, VT[k].crm, VT[k].o2, VT[k].wd);
      if (!VT[k].wr) check(int'(VT[k].req), $sformatf("rdata vec %0d", k), s_rd, VT[k].ex);
      check(int'(VT[k].req), $sformatf("pulse vec %0d", k), {31'b0, s_inv}, {31'b0, VT[k].inv});
    end

    // R7: the pulse lasts one cycle
    run_acc(1'b1, 3'd4, 4'd3, 3'd0, 32'h1);
    run_acc(1'b0, 3'd4, 4'd3, 3'd0, 32'h0);
    check(7, "R7 pulse single cycle", {31'b0, s_inv}, 32'h0);

    // R11: degenerate configurations report no regions and hold nothing
    run_acc(1'b0, 3'd4, 4'd0, 3'd4, 32'h0);
    check(11, "R11 absent hyp id", s_off, 32'h0);
    check(11, "R11 no-lower hyp id", s_nolo, 32'h0);
    check(8, "R8 hyp id again", s_rd, 32'(HI_N));
    run_acc(1'b0, 3'd0, 4'd0, 3'd4, 32'h0);
    check(11, "R11 absent lower id", s_off, 32'h0);
    check(8, "R8 lower id", s_rd, 32'(LO_N * 256));
    run_acc(1'b1, 3'd4, 4'd8, 3'd0, 32'h77);
    run_acc(1'b0, 3'd4, 4'd8, 3'd0, 32'h0);
    check(11, "R11 absent alias 0", s_off, 32'h0);
    check(11, "R11 no-lower alias 0", s_nolo, 32'h0);
    check(3, "R3 alias 0 stored", s_rd, 32'h77);

    // R9: reset mid-run wipes both banks and selectors
    @(negedge clk);
    acc_wr = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_acc(1'b0, 3'd5, 4'd9, 3'd5, 32'h0);
    check(9, "R9 hyp alias 19 limit", s_rd, 32'h0);
    run_acc(1'b0, 3'd0, 4'd13, 3'd4, 32'h0);
    check(9, "R9 lower alias 11 base", s_rd, 32'h0);
    run_acc(1'b0, 3'd0, 4'd2, 3'd1, 32'h0);
    check(9, "R9 lower selector", s_rd, 32'h0);
    run_acc(1'b0, 3'd4, 4'd2, 3'd1, 32'h0);
    check(9, "R9 hyp selector", s_rd, 32'h0);
    run_acc(1'b0, 3'd4, 4'd1, 3'd1, 32'h0);
    check(9, "R9 bitmap", s_rd, 32'h0);
    check(9, "R9 pulse", {31'b0, s_inv}, 32'h0);

    @(negedge clk);
    acc_wr = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule